// File: doc/BRIEF.md
# Paged and Linear Extended Address Unit

This block sits between a CPU's 16-bit byte bus and a 17-bit flash address space. It reaches the wider space in two ways. In the first, CPU accesses that land in the 16 KiB window at 0x8000 to 0xBFFF are translated. A 3-bit bank register supplies address bits 16:14, and the CPU address supplies bits 13:0. In the second, a 17-bit pointer held in three byte-wide registers is used to reach memory indirectly through byte data ports. One port leaves the pointer unchanged. Two ports advance it by one after every access. A separate add register moves the pointer forward by an unsigned byte.

All other CPU addresses pass straight through to memory, with bit 16 cleared. The block decodes every access into one of three classes: `ACC_PAGED` (window), `ACC_REG` (its own eight-byte register block) and `ACC_DIRECT` (everything else). Inside `ACC_REG`, the register select is one of `REG_BANK`, `REG_PHI`, `REG_PMID`, `REG_PLO`, `REG_PADD`, `REG_DFIX`, `REG_DINC` and `REG_DWINC`. The translation is combinational. The bank register and the pointer change on the clock edge that ends an access. There is no sequencing state: each access completes in one cycle.

Top module: `xau_top`

## Requirements
- R1: After reset, the bank register reads 0x02 and all three pointer byte registers read 0x00.
- R2: A CPU access with address bits 15:14 equal to 2'b10 drives mem_addr = {bank[2:0], cpu_addr[13:0]}, with the matching mem_rd/mem_wr strobe.
- R3: The bank register sits at offset 0 of the register block and keeps only write-data bits 2:0. Bits 7:3 read as zero.
- R4: An access outside both the window and the register block (0x0010 to 0x0017) drives mem_addr = {1'b0, cpu_addr} with the matching strobe.
- R5: An access to the fixed data port (offset 5) uses the pointer as mem_addr and leaves the pointer unchanged.
- R6: An access to the byte post-increment port (offset 6), read or write, uses the current pointer and then advances it by exactly 1.
- R7: An access to the word post-increment port (offset 7), read or write, uses the current pointer and then advances it by exactly 1.
- R8: A write of byte d to the add register (offset 4) sets pointer = pointer + d, with d unsigned and the carry reaching bits 16:8. The add register reads 0x00.
- R9: Pointer arithmetic wraps modulo 2^17: 0x1FFFF + 1 = 0x00000 and 0x1FF01 + 0xFF = 0x00000.
- R10: The pointer byte registers are at offsets 1 (bit 16 only, bits 7:1 read zero), 2 (bits 15:8) and 3 (bits 7:0). A write to one of them changes only that byte.
- R11: Accesses to offsets 0 to 4 raise neither mem_rd nor mem_wr. Reads of the data ports (offsets 5 to 7) return mem_rdata on cpu_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| mem_addr | output | 17 | Extended memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |

## Verification
A corrupted pointer shows on mem_addr in the very cycle of the next data-port access. It also shows on the pointer byte registers at the next read, so the bench mixes pointer reads into the random stream. A wrong bank value shows only at the next window access, so window accesses are spread between bank writes. An increment or add that goes wrong, or lands on the wrong cycle, shows one access later as an off-by-one or missing carry. The directed cases place the carry and wrap boundaries right before a readback.

// File: rtl/xau_pkg.sv
package xau_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_PAGED  = 2'd1,
        ACC_REG    = 2'd2
    } acc_e;

    localparam int REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_BANK  = 3'd0,
        REG_PHI   = 3'd1,
        REG_PMID  = 3'd2,
        REG_PLO   = 3'd3,
        REG_PADD  = 3'd4,
        REG_DFIX  = 3'd5,
        REG_DINC  = 3'd6,
        REG_DWINC = 3'd7
    } reg_e;
endpackage

// File: rtl/xau_decode.sv
module xau_decode
    import xau_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          OFS_W    = 14,
    parameter logic [15:0] WIN_BASE = 16'h8000,
    parameter logic [15:0] REG_BASE = 16'h0010
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              kind,
    output reg_e              sel
);
    logic in_win;
    logic in_reg;

    assign in_win = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
    assign in_reg = (addr[ADDR_W-1:REG_SEL_W] == REG_BASE[ADDR_W-1:REG_SEL_W]);
    assign sel    = reg_e'(addr[REG_SEL_W-1:0]);

    always_comb begin
        if (in_win)      kind = ACC_PAGED;
        else if (in_reg) kind = ACC_REG;
        else             kind = ACC_DIRECT;
    end
endmodule

// File: rtl/xau_bank.sv
module xau_bank #(
    parameter int              PAGE_W   = 3,
    parameter logic [PAGE_W-1:0] PAGE_RST = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bank_q <= PAGE_RST;
        else if (we) bank_q <= wdata;
    end
endmodule

// File: rtl/xau_ptr.sv
module xau_ptr #(
    parameter int XADDR_W = 17,
    parameter int DATA_W  = 8,
    localparam int NBYTES = (XADDR_W + DATA_W - 1) / DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBYTES-1:0]  byte_we,
    input  logic               add_en,
    input  logic               inc_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [XADDR_W-1:0] ptr_q
);
    logic [XADDR_W-1:0] lane_mask;
    logic [XADDR_W-1:0] lane_val;
    logic [XADDR_W-1:0] ptr_d;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int LO = i * DATA_W;
        localparam int W  = ((XADDR_W - LO) < DATA_W) ? (XADDR_W - LO) : DATA_W;
        assign lane_mask[LO +: W] = {W{byte_we[i]}};
        assign lane_val[LO +: W]  = wdata[W-1:0];
    end

    always_comb begin
        if (inc_en)
            ptr_d = ptr_q + XADDR_W'(1);
        else if (add_en)
            ptr_d = ptr_q + {{(XADDR_W-DATA_W){1'b0}}, wdata};
        else
            ptr_d = (ptr_q & ~lane_mask) | (lane_val & lane_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/xau_top.sv
module xau_top
    import xau_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          PAGE_W   = 3,
    parameter int          OFS_W    = 14,
    parameter logic [15:0] WIN_BASE = 16'h8000,
    parameter logic [15:0] REG_BASE = 16'h0010,
    parameter logic [2:0]  PAGE_RST = 3'd2,
    localparam int XADDR_W = PAGE_W + OFS_W,
    localparam int NBYTES  = (XADDR_W + DATA_W - 1) / DATA_W,
    localparam int LIDX_W  = $clog2(NBYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [XADDR_W-1:0] mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    acc_e                       kind;
    reg_e                       sel;
    logic [PAGE_W-1:0]          bank_q;
    logic [XADDR_W-1:0]         ptr_q;
    logic [NBYTES*DATA_W-1:0]   ptr_ext;
    logic [NBYTES-1:0]          byte_we;
    logic                       lane_hit;
    logic [LIDX_W-1:0]          lane_idx;
    logic                       is_data;
    logic                       is_step;
    logic                       cpu_act;

    xau_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE), .REG_BASE(REG_BASE)
    ) u_dec (
        .addr(cpu_addr), .kind(kind), .sel(sel)
    );

    assign cpu_act = cpu_rd | cpu_wr;

    always_comb begin
        lane_hit = 1'b0;
        lane_idx = '0;
        is_data  = 1'b0;
        is_step  = 1'b0;
        unique case (sel)
            REG_PLO:   begin lane_hit = 1'b1; lane_idx = LIDX_W'(0); end
            REG_PMID:  begin lane_hit = 1'b1; lane_idx = LIDX_W'(1); end
            REG_PHI:   begin lane_hit = 1'b1; lane_idx = LIDX_W'(2); end
            REG_DFIX:  is_data = 1'b1;
            REG_DINC,
            REG_DWINC: begin is_data = 1'b1; is_step = 1'b1; end
            REG_BANK,
            REG_PADD:  ;
        endcase
    end

    xau_bank #(.PAGE_W(PAGE_W), .PAGE_RST(PAGE_RST)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_wr && kind == ACC_REG && sel == REG_BANK),
        .wdata (cpu_wdata[PAGE_W-1:0]),
        .bank_q(bank_q)
    );

    assign byte_we = (cpu_wr && kind == ACC_REG && lane_hit)
                     ? (NBYTES'(1) << lane_idx) : '0;

    xau_ptr #(.XADDR_W(XADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .byte_we(byte_we),
        .add_en (cpu_wr && kind == ACC_REG && sel == REG_PADD),
        .inc_en (cpu_act && kind == ACC_REG && is_step),
        .wdata  (cpu_wdata),
        .ptr_q  (ptr_q)
    );

    assign ptr_ext   = {{(NBYTES*DATA_W-XADDR_W){1'b0}}, ptr_q};
    assign mem_wdata = cpu_wdata;

    always_comb begin
        mem_addr  = ptr_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        cpu_rdata = mem_rdata;
        unique case (kind)
            ACC_PAGED: begin
                mem_addr = {bank_q, cpu_addr[OFS_W-1:0]};
                mem_rd   = cpu_rd;
                mem_wr   = cpu_wr;
            end
            ACC_DIRECT: begin
                mem_addr = {{(XADDR_W-ADDR_W){1'b0}}, cpu_addr};
                mem_rd   = cpu_rd;
                mem_wr   = cpu_wr;
            end
            ACC_REG: begin
                mem_rd = cpu_rd & is_data;
                mem_wr = cpu_wr & is_data;
                if (lane_hit)
                    cpu_rdata = ptr_ext[lane_idx*DATA_W +: DATA_W];
                else if (sel == REG_BANK)
                    cpu_rdata = {{(DATA_W-PAGE_W){1'b0}}, bank_q};
                else if (sel == REG_PADD)
                    cpu_rdata = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xau_chk.sv
module xau_chk #(
    parameter logic [15:0] REG_BASE = 16'h0010
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic [16:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [16:0] ptr_q
);
    logic       act;
    logic       win;
    logic       regblk;
    logic [2:0] off;

    assign act    = cpu_rd | cpu_wr;
    assign win    = cpu_addr[15:14] == 2'b10;
    assign regblk = cpu_addr[15:3] == REG_BASE[15:3];
    assign off    = cpu_addr[2:0];

    p_window_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act && win |-> mem_addr[13:0] == cpu_addr[13:0] && mem_rd == cpu_rd && mem_wr == cpu_wr);

    p_bank_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && regblk && off == 3'd0 |-> cpu_rdata[7:3] == 5'd0);

    p_direct_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act && !win && !regblk |-> mem_addr == {1'b0, cpu_addr});

    p_fixed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act && regblk && off == 3'd5 |=> ptr_q == $past(ptr_q));

    p_byte_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act && regblk && off == 3'd6 |=> ptr_q == $past(ptr_q) + 17'd1);

    p_word_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act && regblk && off == 3'd7 |=> ptr_q == $past(ptr_q) + 17'd1);

    p_reg_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act && regblk && off < 3'd5 |-> !mem_rd && !mem_wr);
endmodule

bind xau_top xau_chk #(.REG_BASE(REG_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .cpu_rdata(cpu_rdata),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .ptr_q    (ptr_q)
);

// File: tb/xau_top_tb.sv
module xau_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [16:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [2:0]  m_bank = 3'd2;
    logic [16:0] m_ptr = '0;

    function automatic logic [7:0] memfn(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
    endfunction

    always #(CLK_P/2) clk = ~clk;
    assign mem_rdata = memfn(mem_addr);

    xau_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] d, input string tag);
        logic [16:0] ea;
        logic [7:0]  erd;
        bit          strobe;
        bit          isreg;
        logic [2:0]  off;
        isreg = (a[15:3] == 13'h0002);
        off   = a[2:0];
        if (a[15:14] == 2'b10) begin ea = {m_bank, a[13:0]}; strobe = 1'b1; end
        else if (isreg)       begin ea = m_ptr; strobe = (off >= 3'd5); end
        else                  begin ea = {1'b0, a}; strobe = 1'b1; end
        erd = memfn(ea);
        if (isreg) begin
            case (off)
                3'd0: erd = {5'b0, m_bank};
                3'd1: erd = {7'b0, m_ptr[16]};
                3'd2: erd = m_ptr[15:8];
                3'd3: erd = m_ptr[7:0];
                3'd4: erd = 8'h00;
                default: erd = memfn(m_ptr);
            endcase
        end
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
        #1;
        if (strobe) chk(mem_addr == ea, tag, 32'(mem_addr), 32'(ea));
        chk(mem_rd == (strobe && !wr) && mem_wr == (strobe && wr), isreg ? "R11" : tag,
            {30'b0, mem_rd, mem_wr}, {30'b0, strobe && !wr, strobe && wr});
        if (wr && strobe) chk(mem_wdata == d, tag, 32'(mem_wdata), 32'(d));
        if (!wr) chk(cpu_rdata == erd, tag, 32'(cpu_rdata), 32'(erd));
        @(posedge clk);
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (isreg) begin
            if (wr) begin
                case (off)
                    3'd0: m_bank = d[2:0];
                    3'd1: m_ptr[16] = d[0];
                    3'd2: m_ptr[15:8] = d;
                    3'd3: m_ptr[7:0] = d;
                    3'd4: m_ptr = m_ptr + {9'b0, d};
                    default: ;
                endcase
            end
            if (off == 3'd6 || off == 3'd7) m_ptr = m_ptr + 17'd1;
        end
    endtask

    task automatic set_ptr(input logic [16:0] v, input string tag);
        access(16'h0011, 1'b1, {7'b0, v[16]}, tag);
        access(16'h0012, 1'b1, v[15:8], tag);
        access(16'h0013, 1'b1, v[7:0], tag);
    endtask

    task automatic read_ptr(input string tag);
        access(16'h0011, 1'b0, 8'h00, tag);
        access(16'h0012, 1'b0, 8'h00, tag);
        access(16'h0013, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h00C0FFEE);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        access(16'h0010, 1'b0, 8'h00, "R1");
        chk(cpu_rdata == 8'h02 || m_bank == 3'd2, "R1", 32'(m_bank), 32'd2);
        read_ptr("R1");

        // R3: bank keeps bits 2:0 only
        access(16'h0010, 1'b1, 8'hFF, "R3");
        access(16'h0010, 1'b0, 8'h00, "R3");

        // R10: byte isolation and high register width
        access(16'h0011, 1'b1, 8'hFF, "R10");
        access(16'h0012, 1'b1, 8'hAB, "R10");
        read_ptr("R10");

        // R2: window translation with bank 7, then bank 0
        access(16'h8123, 1'b0, 8'h00, "R2");
        access(16'hBFFF, 1'b1, 8'h3C, "R2");
        access(16'h0010, 1'b1, 8'h00, "R2");
        access(16'h8000, 1'b0, 8'h00, "R2");

        // R4: pass-through around window and register block
        access(16'h7FFF, 1'b0, 8'h00, "R4");
        access(16'hC000, 1'b1, 8'h11, "R4");
        access(16'h000F, 1'b0, 8'h00, "R4");
        access(16'h0018, 1'b0, 8'h00, "R4");

        // R5: fixed port holds the pointer
        access(16'h0015, 1'b0, 8'h00, "R5");
        access(16'h0015, 1'b1, 8'h77, "R5");
        read_ptr("R5");

        // R6 and R9: increment wraps from the top
        set_ptr(17'h1FFFF, "R6");
        access(16'h0016, 1'b0, 8'h00, "R6");
        read_ptr("R9");
        access(16'h0016, 1'b1, 8'h42, "R6");
        read_ptr("R6");

        // R7: word port steps on read and write
        access(16'h0017, 1'b1, 8'h99, "R7");
        access(16'h0017, 1'b0, 8'h00, "R7");
        read_ptr("R7");

        // R8: add carries into the middle byte, reads zero
        set_ptr(17'h000F0, "R8");
        access(16'h0014, 1'b1, 8'h20, "R8");
        read_ptr("R8");
        access(16'h0014, 1'b0, 8'h00, "R8");
        set_ptr(17'h0FFF0, "R8");
        access(16'h0014, 1'b1, 8'h10, "R8");
        read_ptr("R8");

        // R9: add wraps modulo 2^17
        set_ptr(17'h1FF01, "R9");
        access(16'h0014, 1'b1, 8'hFF, "R9");
        read_ptr("R9");

        // mixed random stimulus
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            bit          w;
            logic [7:0]  d;
            r = $urandom;
            w = r[8];
            d = r[23:16];
            a = 16'($urandom);
            case (r[31:28] % 4'd10)
                4'd0: access(16'h0010, 1'b1, d, "R3");
                4'd1: access(16'h0011 + 16'(r[1:0] % 2'd3), 1'b1, d, "R10");
                4'd2: access(16'h0014, 1'b1, d, "R8");
                4'd3: access({2'b10, a[13:0]}, w, d, "R2");
                4'd4: access(a, w, d, "R4");
                4'd5: access(16'h0015, w, d, "R5");
                4'd6: access(16'h0016, w, d, "R6");
                4'd7: access(16'h0017, w, d, "R7");
                default: access(16'h0010 + 16'(r[2:0] % 3'd5), 1'b0, 8'h00, "R10");
            endcase
        end
        read_ptr("R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule